// File: doc/BRIEF.md
# SPI Master Transaction Engine with Programmable Delays

This block runs complete SPI transactions on behalf of a host. The host sets up a transfer through a small write-only register port: the clock mode, the SCK half-period, a 16-bit byte count, a 9-bit chip-select pattern for quiet periods, a 9-bit pattern for active transfers, and three delays. The three delays are the lead time after chip select, the gap between bytes, and the trail time before chip select is released. A start pulse launches the transfer. Transmit bytes are pulled from the host with a valid/ready handshake. Each received byte is handed back with a one-deep valid/ready slot.

Every delay and every SCK half-period is counted in one prescaled tick of D clock cycles, where D is the programmed half-period. A delay of zero removes its phase. The configuration is captured when a transfer starts. A cancel input stops the transfer at the next byte boundary, still applies the trail delay, and reports the abort. A busy flag, and an active-low copy of it for an activity LED, show when a transfer is running.

Top module: `spim_master`

## Requirements
- R1: While reset is held and after it is released, the block shows cs_o = 9'h1FF, sck = 0, mosi = 0, busy = 0, led_n = 1, done = 0 and aborted = 0.
- R2: After reset the configuration is: mode 0, a half-period of DEF_HALF = CLK_HZ/(2*DEF_BPS) cycles (25 cycles, or 1 Mbit/s, at the 50 MHz default), 4 bytes, active pattern 9'h1FD (only line 1 low) and all delays zero. A start with no register writes runs that transfer.
- R3: The mode is written at register address 0, bits [1:0] = {CPOL, CPHA}. SCK rests at CPOL while quiet. Data is sent MSB first. MOSI is stable at the slave sampling edge, which is the rising edge in modes 0 and 3 and the falling edge in modes 1 and 2. MISO is captured on that same edge.
- R4: The lead delay L is at address 5, and the half-period D is at address 1 (a value of 0 counts as 1). The first SCK edge comes L*D + D + 2 cycles after chip select turns active.
- R5: The gap delay G is at address 6. When the next transmit byte is already offered, the first edge of a byte comes G*D + D + 2 cycles after the last edge of the byte before it.
- R6: The trail delay T is at address 7. T*D + 1 cycles after the last SCK edge, cs_o returns to the idle pattern, busy falls, and done pulses high for one cycle.
- R7: The idle pattern is at address 3 and the active pattern at address 4, both 9 bits. cs_o holds the active pattern without change for the whole transfer. While quiet, cs_o follows the idle register one cycle after it is written.
- R8: The byte count N is at address 2 and is 16 bits wide. Exactly N bytes are shifted, and each one comes back on rx_data with rx_valid. A start with N = 0 is ignored.
- R9: led_n is low exactly while busy is high.
- R10: A cancel pulse lets the current byte finish and starts no further byte. The trail delay then runs, the idle pattern returns, and aborted pulses together with done.
- R11: Register writes and start pulses made while busy do not affect the running transfer. The writes apply to the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| start | input | 1 | Launch a transfer (ignored while busy) |
| cancel | input | 1 | End the transfer at the next byte boundary |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Engine takes the offered byte this cycle |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Host takes the received byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 9 | Chip-select lines |
| busy | output | 1 | Transfer in progress |
| led_n | output | 1 | Activity indicator, low while busy |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| aborted | output | 1 | One-cycle pulse with done when the transfer was cancelled |

## Verification
A table of transfers covers all four modes. The table pairs different half-periods, byte counts, delay triples and chip-select patterns, so a mistake in the lead, gap or trail count shows up as a cycle mismatch of a known size.

MISO is looped back inverted. A separate slave model samples MOSI on the edge that the mode dictates. Together they tell a wrong launch edge apart from a wrong capture edge.

Directed runs check the following:
- The reset defaults, including the 1 Mbit/s timing.
- A 300-byte transfer, whose count does not fit in 8 bits.
- A zero count.
- A cancel in the middle of a byte.
- Reprogramming and a second start while a transfer is busy.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int CS_N = 9;
    localparam int CW   = 16;
    localparam int BW   = 8;
    localparam int HW   = $clog2(2 * BW);
    localparam logic [HW-1:0] LAST_H = HW'(2 * BW - 1);
    localparam logic [CS_N-1:0] DEF_IDLE = {CS_N{1'b1}};
    localparam logic [CS_N-1:0] DEF_ACT  = ~(CS_N'(1) << 1);
    localparam logic [CW-1:0]   DEF_CNT  = CW'(4);

    typedef struct packed {
        logic [1:0]      mode;
        logic [CW-1:0]   div;
        logic [CW-1:0]   count;
        logic [CS_N-1:0] idle_cs;
        logic [CS_N-1:0] act_cs;
        logic [CW-1:0]   lead;
        logic [CW-1:0]   gap;
        logic [CW-1:0]   trail;
    } cfg_t;

    typedef enum logic [2:0] {S_IDLE, S_LEAD, S_WAIT, S_XFER, S_GAP, S_TRAIL} st_t;

    typedef struct packed {
        st_t             state;
        logic [CW-1:0]   dcnt;
        logic [HW-1:0]   hcnt;
        logic [CW-1:0]   bleft;
        logic [BW-1:0]   txsh;
        logic [BW-1:0]   rxsh;
        logic            mosi;
        logic            sck;
        logic [CS_N-1:0] cs;
        logic            pend;
        logic [BW-1:0]   rxd;
        logic            rxv;
        logic            done;
        logic            aborted;
        logic [1:0]      mode;
        logic [CW-1:0]   div;
        logic [CW-1:0]   gap;
        logic [CW-1:0]   trail;
    } eng_t;
endpackage

// File: rtl/spim_cfg.sv
module spim_cfg
    import spim_pkg::*;
#(
    parameter logic [CW-1:0] DEF_HALF = CW'(25)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [2:0]  addr,
    input  logic [CW-1:0] wdata,
    output cfg_t        cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                3'd0: cfg_d.mode    = wdata[1:0];
                3'd1: cfg_d.div     = wdata;
                3'd2: cfg_d.count   = wdata;
                3'd3: cfg_d.idle_cs = wdata[CS_N-1:0];
                3'd4: cfg_d.act_cs  = wdata[CS_N-1:0];
                3'd5: cfg_d.lead    = wdata;
                3'd6: cfg_d.gap     = wdata;
                3'd7: cfg_d.trail   = wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q         <= '0;
            cfg_q.div     <= DEF_HALF;
            cfg_q.count   <= DEF_CNT;
            cfg_q.idle_cs <= DEF_IDLE;
            cfg_q.act_cs  <= DEF_ACT;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/spim_tick.sv
module spim_tick
    import spim_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          clr,
    input  logic [CW-1:0] div,
    output logic          tick
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim   = (div == '0) ? CW'(0) : div - CW'(1);
        tick  = en && (cnt_q == lim);
        cnt_d = cnt_q + CW'(1);
        if (!en || clr || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  cfg_t            cfg,
    input  logic            start,
    input  logic            cancel,
    input  logic            tick,
    input  logic            tx_valid,
    input  logic [BW-1:0]   tx_data,
    output logic            tx_ready,
    input  logic            rx_ready,
    input  logic            miso,
    output logic            rx_valid,
    output logic [BW-1:0]   rx_data,
    output logic            sck,
    output logic            mosi,
    output logic [CS_N-1:0] cs_o,
    output logic            busy,
    output logic            done,
    output logic            aborted,
    output logic            tick_en,
    output logic            tick_clr,
    output logic [CW-1:0]   div
);
    eng_t d, q;
    logic stop_req;

    always_comb begin
        d = q;
        d.done    = 1'b0;
        d.aborted = 1'b0;
        if (rx_ready) d.rxv = 1'b0;
        stop_req = q.pend | cancel;
        tx_ready = (q.state == S_WAIT) && !q.rxv && !stop_req;
        if (q.state != S_IDLE && q.state != S_TRAIL && cancel) d.pend = 1'b1;

        case (q.state)
            S_IDLE: begin
                d.cs   = cfg.idle_cs;
                d.sck  = cfg.mode[1];
                d.pend = 1'b0;
                if (start && cfg.count != '0) begin
                    d.state = S_LEAD;
                    d.cs    = cfg.act_cs;
                    d.bleft = cfg.count;
                    d.dcnt  = cfg.lead;
                    d.mode  = cfg.mode;
                    d.div   = cfg.div;
                    d.gap   = cfg.gap;
                    d.trail = cfg.trail;
                end
            end
            S_LEAD, S_GAP: begin
                if (stop_req) begin
                    d.state = S_TRAIL;
                    d.dcnt  = q.trail;
                end else if (q.dcnt == '0) begin
                    d.state = S_WAIT;
                end else if (tick) begin
                    d.dcnt = q.dcnt - CW'(1);
                end
            end
            S_WAIT: begin
                if (stop_req) begin
                    d.state = S_TRAIL;
                    d.dcnt  = q.trail;
                end else if (tx_valid && tx_ready) begin
                    d.state = S_XFER;
                    d.hcnt  = '0;
                    d.rxsh  = '0;
                    if (!q.mode[0]) begin
                        d.mosi = tx_data[BW-1];
                        d.txsh = {tx_data[BW-2:0], 1'b0};
                    end else begin
                        d.txsh = tx_data;
                    end
                end
            end
            S_XFER: begin
                if (tick) begin
                    d.sck  = ~q.sck;
                    d.hcnt = q.hcnt + HW'(1);
                    if (q.hcnt[0] == q.mode[0]) begin
                        d.rxsh = {q.rxsh[BW-2:0], miso};
                    end else if (!(!q.mode[0] && q.hcnt == LAST_H)) begin
                        d.mosi = q.txsh[BW-1];
                        d.txsh = {q.txsh[BW-2:0], 1'b0};
                    end
                    if (q.hcnt == LAST_H) begin
                        d.rxd   = d.rxsh;
                        d.rxv   = 1'b1;
                        d.bleft = q.bleft - CW'(1);
                        if (q.bleft == CW'(1) || stop_req) begin
                            d.state = S_TRAIL;
                            d.dcnt  = q.trail;
                        end else begin
                            d.state = S_GAP;
                            d.dcnt  = q.gap;
                        end
                    end
                end
            end
            S_TRAIL: begin
                if (q.dcnt == '0) begin
                    d.state   = S_IDLE;
                    d.cs      = cfg.idle_cs;
                    d.done    = 1'b1;
                    d.aborted = q.pend;
                end else if (tick) begin
                    d.dcnt = q.dcnt - CW'(1);
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.cs <= DEF_IDLE;
        end else begin
            q <= d;
        end
    end

    assign tick_en  = (q.state == S_LEAD) || (q.state == S_XFER) ||
                      (q.state == S_GAP)  || (q.state == S_TRAIL);
    assign tick_clr = (d.state != q.state);
    assign div      = q.div;
    assign rx_valid = q.rxv;
    assign rx_data  = q.rxd;
    assign sck      = q.sck;
    assign mosi     = q.mosi;
    assign cs_o     = q.cs;
    assign busy     = (q.state != S_IDLE);
    assign done     = q.done;
    assign aborted  = q.aborted;
endmodule

// File: rtl/spim_master.sv
module spim_master
    import spim_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int DEF_BPS = 1_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [15:0] cfg_wdata,
    input  logic        start,
    input  logic        cancel,
    input  logic        tx_valid,
    input  logic [7:0]  tx_data,
    output logic        tx_ready,
    output logic        rx_valid,
    output logic [7:0]  rx_data,
    input  logic        rx_ready,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic [8:0]  cs_o,
    output logic        busy,
    output logic        led_n,
    output logic        done,
    output logic        aborted
);
    localparam logic [CW-1:0] DEF_HALF = CW'(CLK_HZ / (2 * DEF_BPS));

    cfg_t          cfg_live;
    logic          tick, tick_en, tick_clr;
    logic [CW-1:0] tick_div;

    spim_cfg #(.DEF_HALF(DEF_HALF)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .cfg(cfg_live)
    );

    spim_tick u_tick (
        .clk(clk), .rst_n(rst_n), .en(tick_en), .clr(tick_clr),
        .div(tick_div), .tick(tick)
    );

    spim_engine u_eng (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_live), .start(start),
        .cancel(cancel), .tick(tick), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_ready(rx_ready),
        .miso(miso), .rx_valid(rx_valid), .rx_data(rx_data), .sck(sck),
        .mosi(mosi), .cs_o(cs_o), .busy(busy), .done(done),
        .aborted(aborted), .tick_en(tick_en), .tick_clr(tick_clr),
        .div(tick_div)
    );

    assign led_n = ~busy;
endmodule

// File: rtl/spim_master_chk.sv
module spim_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       led_n,
    input logic       sck,
    input logic [8:0] cs_o,
    input logic       done,
    input logic       aborted,
    input logic       rx_valid,
    input logic [8:0] idle_cs,
    input logic       cpol
);
    // R7: quiet lines follow the idle register
    a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> cs_o == $past(idle_cs));

    // R7: active pattern held while busy
    a_r7_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_o));

    // R3: clock rests at CPOL while quiet
    a_r3_sck_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> sck == $past(cpol));

    // R6: done marks the end of a busy period
    a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R10: aborted only comes together with done
    a_r10_abort_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |-> done);

    // R8: a received byte appears only during a transfer
    a_r8_rx_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> busy);

    // R9: indicator low while a transfer runs
    a_r9_led_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !led_n);
endmodule

bind spim_master spim_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .led_n(led_n), .sck(sck),
    .cs_o(cs_o), .done(done), .aborted(aborted), .rx_valid(rx_valid),
    .idle_cs(cfg_live.idle_cs), .cpol(cfg_live.mode[1])
);

// File: tb/sim_spim_master.sv
module sim_spim_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        start = 1'b0, cancel = 1'b0;
    logic        tx_valid = 1'b1, rx_ready = 1'b1;
    logic [7:0]  tx_data, rx_data;
    logic        tx_ready, rx_valid, sck, mosi, miso, busy, led_n, done, aborted;
    logic [8:0]  cs_o;

    always #10 clk = ~clk;

    spim_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .cancel(cancel),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_o(cs_o), .busy(busy),
        .led_n(led_n), .done(done), .aborted(aborted)
    );

    function automatic logic [7:0] fb(input int i);
        return 8'(i * 29 + 60);
    endfunction

    int tx_idx = 0;
    always @(posedge clk) if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
    assign tx_data = fb(tx_idx);
    assign miso = ~mosi;

    // slave view: samples MOSI on the edge the mode dictates
    logic [1:0] cur_mode = 2'd0;
    logic       sbits [0:8191];
    int         sbit = 0;
    always @(sck) begin
        if (busy && ((sck == 1'b1) == (cur_mode == 2'd0 || cur_mode == 2'd3))) begin
            sbits[sbit] = mosi;
            sbit = sbit + 1;
        end
    end

    // port monitor
    logic       mon_clr = 1'b0;
    int         cyc = 0, t_busy, t_idle, t_last, n_edges, n_rx, cs_bad, led_bad;
    int         edge_t [0:39];
    logic [7:0] rx_buf [0:511];
    logic       busy_seen, idle_seen, done_seen, abort_seen, sck_prev;
    logic [8:0] cs_act;
    always @(negedge clk) begin
        if (mon_clr) begin
            busy_seen = 0; idle_seen = 0; done_seen = 0; abort_seen = 0;
            n_edges = 0; n_rx = 0; cs_bad = 0; led_bad = 0;
        end else begin
            if (busy && !busy_seen) begin busy_seen = 1; t_busy = cyc; cs_act = cs_o; end
            if (busy_seen && busy && cs_o != cs_act) cs_bad = cs_bad + 1;
            if (busy && sck != sck_prev) begin
                if (n_edges < 40) edge_t[n_edges] = cyc;
                t_last = cyc;
                n_edges = n_edges + 1;
            end
            if (rx_valid) begin
                if (n_rx < 512) rx_buf[n_rx] = rx_data;
                n_rx = n_rx + 1;
            end
            if (done) done_seen = 1;
            if (aborted) abort_seen = 1;
            if (busy_seen && !busy && !idle_seen) begin idle_seen = 1; t_idle = cyc; end
            if (led_n == busy) led_bad = led_bad + 1;
        end
        sck_prev = sck;
        cyc = cyc + 1;
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(v);
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); #1; start = 1'b1;
        @(negedge clk); #1; start = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk); #1; mon_clr = 1'b1;
        @(negedge clk); #1; mon_clr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 20000 && !idle_seen; k++) begin
            @(negedge clk); #1;
        end
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic run_check(input int md, input int dv, input int cnt, input int ld,
                             input int gp, input int tr, input int idl, input int act);
        int base, sbase, dd, ncmp;
        logic [7:0] sb;
        cur_mode = 2'(md);
        clear_mon();
        base = tx_idx; sbase = sbit;
        dd = (dv == 0) ? 1 : dv;
        pulse_start();
        wait_idle();
        chk(n_rx == cnt, "R8 byte count", n_rx, cnt);
        chk(done_seen, "R6 done pulse", done_seen, 1);
        chk(!abort_seen, "R10 no abort", abort_seen, 0);
        chk(cs_act == 9'(act) && cs_bad == 0, "R7 active pattern", cs_act, act);
        chk(cs_o == 9'(idl), "R7 idle pattern", cs_o, idl);
        chk(sck == md[1], "R3 sck rest level", sck, md[1]);
        chk(led_bad == 0, "R9 led tracks busy", led_bad, 0);
        chk(edge_t[0] - t_busy == ld * dd + dd + 2, "R4 lead timing", edge_t[0] - t_busy, ld * dd + dd + 2);
        if (cnt >= 2)
            chk(edge_t[16] - edge_t[15] == gp * dd + dd + 2, "R5 gap timing",
                edge_t[16] - edge_t[15], gp * dd + dd + 2);
        chk(t_idle - t_last == tr * dd + 1, "R6 trail timing", t_idle - t_last, tr * dd + 1);
        ncmp = (cnt < 16) ? cnt : 16;
        for (int k = 0; k < ncmp; k++) begin
            chk(rx_buf[k] == ~fb(base + k), "R3 miso capture", rx_buf[k], ~fb(base + k));
            for (int b = 0; b < 8; b++) sb[7-b] = sbits[sbase + 8 * k + b];
            chk(sb == fb(base + k), "R3 mosi at slave edge", sb, fb(base + k));
        end
    endtask

    // mode, half-period, count, lead, gap, trail, idle, active
    localparam int NV = 5;
    localparam logic [99:0] VEC [NV] = '{
        {2'd0, 16'd2, 16'd3, 16'd0, 16'd0, 16'd0, 9'h1FF, 9'h1FE},
        {2'd1, 16'd3, 16'd2, 16'd2, 16'd1, 16'd3, 9'h000, 9'h155},
        {2'd2, 16'd1, 16'd4, 16'd1, 16'd0, 16'd1, 9'h0F0, 9'h10F},
        {2'd3, 16'd2, 16'd2, 16'd0, 16'd3, 16'd0, 9'h1FF, 9'h0FF},
        {2'd0, 16'd1, 16'd2, 16'd5, 16'd2, 16'd2, 9'h1AA, 9'h055}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_o == 9'h1FF, "R1 cs in reset", cs_o, 9'h1FF);
        chk(!sck && !mosi && !busy, "R1 sck/mosi/busy", {sck, mosi, busy}, 0);
        chk(led_n && !done && !aborted, "R1 led/done/aborted", {led_n, done, aborted}, 4);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_o == 9'h1FF && led_n, "R1 after release", cs_o, 9'h1FF);

        // R2 defaults: mode 0, 25-cycle half period, 4 bytes, line 1 active
        run_check(0, 25, 4, 0, 0, 0, 9'h1FF, 9'h1FD);

        // table walk
        for (int v = 0; v < NV; v++) begin
            wr(0, VEC[v][99:98]); wr(1, VEC[v][97:82]); wr(2, VEC[v][81:66]);
            wr(5, VEC[v][65:50]); wr(6, VEC[v][49:34]); wr(7, VEC[v][33:18]);
            wr(3, VEC[v][17:9]);  wr(4, VEC[v][8:0]);
            run_check(VEC[v][99:98], VEC[v][97:82], VEC[v][81:66], VEC[v][65:50],
                      VEC[v][49:34], VEC[v][33:18], VEC[v][17:9], VEC[v][8:0]);
        end

        // R8: count wider than 8 bits
        wr(0, 0); wr(1, 1); wr(2, 300); wr(5, 0); wr(6, 0); wr(7, 0);
        wr(3, 9'h1FF); wr(4, 9'h1FE);
        run_check(0, 1, 300, 0, 0, 0, 9'h1FF, 9'h1FE);

        // R8: zero count start is ignored
        wr(2, 0);
        clear_mon();
        pulse_start();
        repeat (40) @(negedge clk);
        #1;
        chk(!busy_seen, "R8 zero count ignored", busy_seen, 0);
        chk(cs_o == 9'h1FF, "R8 zero count cs idle", cs_o, 9'h1FF);

        // R10: cancel mid byte
        wr(1, 2); wr(2, 10); wr(7, 2);
        cur_mode = 2'd0;
        clear_mon();
        pulse_start();
        for (int k = 0; k < 5000 && n_edges < 20; k++) begin @(negedge clk); #1; end
        cancel = 1'b1;
        @(negedge clk); #1; cancel = 1'b0;
        wait_idle();
        chk(n_rx == 2, "R10 bytes after cancel", n_rx, 2);
        chk(abort_seen && done_seen, "R10 aborted and done", {abort_seen, done_seen}, 3);
        chk(t_idle - t_last == 5, "R10 trail after cancel", t_idle - t_last, 5);
        chk(cs_o == 9'h1FF, "R10 idle restored", cs_o, 9'h1FF);

        // R11: writes and start while busy
        wr(7, 0); wr(2, 3); wr(4, 9'h1FD);
        clear_mon();
        pulse_start();
        for (int k = 0; k < 100 && !busy_seen; k++) begin @(negedge clk); #1; end
        wr(4, 9'h0AA); wr(2, 1);
        pulse_start();
        wait_idle();
        chk(n_rx == 3, "R11 count kept while busy", n_rx, 3);
        chk(cs_act == 9'h1FD && cs_bad == 0, "R11 pattern kept while busy", cs_act, 9'h1FD);
        clear_mon();
        pulse_start();
        wait_idle();
        chk(n_rx == 1, "R11 new count next transfer", n_rx, 1);
        chk(cs_act == 9'h0AA, "R11 new pattern next transfer", cs_act, 9'h0AA);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule